// File: doc/BRIEF.md
# Two-Wire Register Slave with Pointer Access

This block is the serial front end of a temperature-monitor macro. It runs a two-wire (I2C-style) slave on a system clock that is much faster than SCL. SCL and SDA pass through a synchroniser. The block drives SDA only through an open-drain enable, where a high `sda_oe` pulls the line low. Its 7-bit bus address is the fixed prefix `1001` followed by three strap pins.

The master first writes a 2-bit register pointer. That pointer then selects one of four registers: a read-only 16-bit temperature value, an 8-bit configuration register, and two 16-bit trip points (hysteresis and over-temperature). Writes always carry a fresh pointer byte. Reads reuse the last pointer until it is changed.

The block has three further functions. A dedicated command byte resets every register to its power-up value. The block releases SDA by itself if it has held the line low for too long. It also emits a one-cycle strobe each time a register read finishes, so that a thermostat beside it can clear an interrupt.

Top module: `tw_reg_slave`

## Requirements
- R1: The slave acknowledges only an address byte whose upper seven bits equal `1001` followed by `dev_pins[2:0]`. Address bit 0 is the direction bit, where 1 means read. Any other address is not acknowledged, and `sda_oe` stays low for the rest of that transaction.
- R2: The low two bits of the pointer byte select the register: 00 temperature, 01 configuration, 10 hysteresis trip point, 11 over-temperature trip point. After reset the pointer selects temperature. A read without a new pointer uses the last pointer written.
- R3: The configuration register is one byte. A write stores bits 6..0. Bit 7 always reads 0, both on `cfg_out` and on the bus.
- R4: A trip-point write takes the MS byte and then the LS byte. Bits 3..0 are stored as zero. A trip-point read returns the MS byte and then the LS byte. Every byte is sent and received MSb first.
- R5: The slave acknowledges the address, the pointer, and each data byte that fits the selected register. A data byte written to the temperature register, a second configuration byte, or a third trip-point byte is not acknowledged and is discarded. Register outputs change only while SCL is high.
- R6: During a read the slave sends the next byte only after the master ACKs. A master NACK ends the read, and it may come right after the MS byte of a two-byte register.
- R7: If the byte after a write address is 0x54, the slave does not acknowledge it. Configuration then returns to 0x00, hysteresis to 0x4B00, over-temperature to 0x5000, and the pointer to temperature.
- R8: If the slave has driven `sda_oe` for `TIMEOUT_CYC` consecutive cycles, it releases SDA and waits for the next START. SDA held low by another device does not start this timer.
- R9: A repeated START after a pointer write starts a read of the newly selected register.
- R10: `rd_strobe` pulses for exactly one cycle when a read ends, that is, at the master's NACK or after the last byte. It never pulses while the slave drives SDA.
- R11: The temperature value is captured when a read address is acknowledged, with bits 3..0 forced to zero. A change of `temp_in` between the MS and LS bytes does not alter the LS byte of that read.
- R12: After reset `sda_oe` and `rd_strobe` are low, and the register outputs hold the values listed in R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad |
| dev_pins | input | 3 | Strapped low address bits |
| temp_in | input | 16 | Current temperature word from the converter |
| sda_oe | output | 1 | High pulls SDA low (open drain) |
| cfg_out | output | 8 | Configuration register, bit 7 always 0 |
| thyst_out | output | 16 | Hysteresis trip point |
| tos_out | output | 16 | Over-temperature trip point |
| rd_strobe | output | 1 | One-cycle pulse when a register read ends |

## Verification
The SDA-low timer and the acknowledge driver both act on `sda_oe`, so they can fall in the same cycle. The bench provokes this by stopping SCL low in the middle of the slave's address acknowledge. The check is that `sda_oe` is still high well before the limit, is low after it, and that the next transaction is served normally. The converse case is also driven: the master holds SDA low for longer than the limit and the block is expected to keep running. A second overlap comes from the temperature input changing between the two bytes of one read. Here the LS byte must come from the value captured at the address, and the next read must return the new value.

// File: rtl/tw_pkg.sv
package tw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_PTR,
        ST_WDATA,
        ST_ACK,
        ST_TX,
        ST_MACK
    } tw_state_e;

    typedef enum logic [1:0] {
        REG_TEMP  = 2'b00,
        REG_CFG   = 2'b01,
        REG_THYST = 2'b10,
        REG_TOS   = 2'b11
    } reg_sel_e;

    localparam logic [3:0]  DEV_PREFIX     = 4'b1001;
    localparam logic [7:0]  SOFT_RESET_CMD = 8'h54;
    localparam logic [15:0] TOS_DEFAULT    = 16'h5000;
    localparam logic [15:0] THYST_DEFAULT  = 16'h4B00;
    localparam logic [6:0]  CFG_DEFAULT    = 7'h00;

    typedef struct packed {
        logic       valid;
        reg_sel_e   sel;
        logic       idx;
        logic [7:0] data;
    } wr_req_t;

    function automatic logic is_wide(reg_sel_e s);
        return s != REG_CFG;
    endfunction

    function automatic logic [7:0] byte_pick(logic [15:0] w, logic idx);
        return idx ? w[7:0] : w[15:8];
    endfunction

    function automatic logic write_fits(reg_sel_e s, logic [1:0] idx);
        case (s)
            REG_CFG:             return idx == 2'd0;
            REG_THYST, REG_TOS:  return !idx[1];
            default:             return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] now_q,
    output logic [LINES-1:0] prev_q
);
    localparam int DEPTH = STAGES + 1;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [DEPTH-1:0] pipe;
        always_ff @(posedge clk) begin
            if (rst) pipe <= '1;
            else     pipe <= {pipe[DEPTH-2:0], raw[g]};
        end
        assign now_q[g]  = pipe[STAGES-1];
        assign prev_q[g] = pipe[STAGES];
    end
endmodule

// File: rtl/tw_reg_file.sv
module tw_reg_file
    import tw_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         soft_rst,
    input  logic         ptr_we,
    input  reg_sel_e     ptr_val,
    input  wr_req_t      wr,
    input  logic         snap,
    input  logic [15:0]  temp_in,
    input  logic         rd_idx,
    output reg_sel_e     ptr,
    output logic [7:0]   rd_byte,
    output logic [7:0]   cfg_out,
    output logic [15:0]  thyst_out,
    output logic [15:0]  tos_out
);
    logic [6:0]  cfg_q;
    logic [15:0] thyst_q, tos_q, temp_snap;

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            ptr     <= REG_TEMP;
            cfg_q   <= CFG_DEFAULT;
            thyst_q <= THYST_DEFAULT;
            tos_q   <= TOS_DEFAULT;
        end else begin
            if (ptr_we) ptr <= ptr_val;
            if (wr.valid) begin
                case (wr.sel)
                    REG_CFG: cfg_q <= wr.data[6:0];
                    REG_THYST: begin
                        if (wr.idx) thyst_q[7:4]  <= wr.data[7:4];
                        else        thyst_q[15:8] <= wr.data;
                    end
                    REG_TOS: begin
                        if (wr.idx) tos_q[7:4]  <= wr.data[7:4];
                        else        tos_q[15:8] <= wr.data;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)       temp_snap <= '0;
        else if (snap) temp_snap <= {temp_in[15:4], 4'h0};
    end

    always_comb begin
        case (ptr)
            REG_TEMP:  rd_byte = byte_pick(temp_snap, rd_idx);
            REG_CFG:   rd_byte = {1'b0, cfg_q};
            REG_THYST: rd_byte = byte_pick(thyst_q, rd_idx);
            default:   rd_byte = byte_pick(tos_q, rd_idx);
        endcase
    end

    assign cfg_out   = {1'b0, cfg_q};
    assign thyst_out = thyst_q;
    assign tos_out   = tos_q;
endmodule

// File: rtl/tw_bus_fsm.sv
module tw_bus_fsm
    import tw_pkg::*;
#(
    parameter int TIMEOUT_CYC = 1000000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        scl,
    input  logic        scl_prev,
    input  logic        sda,
    input  logic        sda_prev,
    input  logic [2:0]  dev_pins,
    input  reg_sel_e    ptr,
    input  logic [7:0]  rd_byte,
    output logic        sda_oe,
    output logic        ptr_we,
    output reg_sel_e    ptr_val,
    output wr_req_t     wr,
    output logic        snap,
    output logic        rd_idx,
    output logic        soft_rst,
    output logic        rd_done
);
    localparam int TW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [TW-1:0] TMO_LAST = TW'(TIMEOUT_CYC - 1);

    tw_state_e      state, after;
    logic           ack_held, more;
    logic [3:0]     bitcnt;
    logic [1:0]     idx;
    logic [7:0]     shreg, txreg;
    logic [TW-1:0]  tmo_cnt;

    logic scl_rise, scl_fall, start_c, stop_c;
    logic [7:0] rx_byte;

    assign scl_rise = scl & ~scl_prev;
    assign scl_fall = ~scl & scl_prev;
    assign start_c  = scl & scl_prev & sda_prev & ~sda;
    assign stop_c   = scl & scl_prev & ~sda_prev & sda;
    assign rx_byte  = {shreg[6:0], sda};
    assign rd_idx   = idx[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            after    <= ST_IDLE;
            ack_held <= 1'b0;
            more     <= 1'b0;
            bitcnt   <= '0;
            idx      <= '0;
            shreg    <= '0;
            txreg    <= '0;
            tmo_cnt  <= '0;
            sda_oe   <= 1'b0;
            ptr_we   <= 1'b0;
            ptr_val  <= REG_TEMP;
            wr       <= '0;
            snap     <= 1'b0;
            soft_rst <= 1'b0;
            rd_done  <= 1'b0;
        end else begin
            ptr_we   <= 1'b0;
            wr.valid <= 1'b0;
            snap     <= 1'b0;
            soft_rst <= 1'b0;
            rd_done  <= 1'b0;
            tmo_cnt  <= sda_oe ? tmo_cnt + 1'b1 : '0;

            if (sda_oe && tmo_cnt == TMO_LAST) begin
                sda_oe <= 1'b0;
                state  <= ST_IDLE;
            end else if (start_c) begin
                state  <= ST_ADDR;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else if (stop_c) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_PTR, ST_WDATA: begin
                        if (scl_rise) begin
                            shreg  <= rx_byte;
                            bitcnt <= bitcnt + 1'b1;
                            if (bitcnt == 4'd7) begin
                                bitcnt   <= '0;
                                ack_held <= 1'b0;
                                if (state == ST_ADDR) begin
                                    if (rx_byte[7:1] == {DEV_PREFIX, dev_pins}) begin
                                        state <= ST_ACK;
                                        idx   <= '0;
                                        after <= rx_byte[0] ? ST_TX : ST_PTR;
                                        snap  <= rx_byte[0];
                                    end else begin
                                        state <= ST_IDLE;
                                    end
                                end else if (state == ST_PTR) begin
                                    if (rx_byte == SOFT_RESET_CMD) begin
                                        soft_rst <= 1'b1;
                                        state    <= ST_IDLE;
                                    end else if (rx_byte[7:2] == 6'd0) begin
                                        ptr_we  <= 1'b1;
                                        ptr_val <= reg_sel_e'(rx_byte[1:0]);
                                        idx     <= '0;
                                        state   <= ST_ACK;
                                        after   <= ST_WDATA;
                                    end else begin
                                        state <= ST_IDLE;
                                    end
                                end else begin
                                    if (write_fits(ptr, idx)) begin
                                        wr    <= '{valid: 1'b1, sel: ptr, idx: idx[0], data: rx_byte};
                                        idx   <= idx + 1'b1;
                                        state <= ST_ACK;
                                        after <= ST_WDATA;
                                    end else begin
                                        state <= ST_IDLE;
                                    end
                                end
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            if (!ack_held) begin
                                sda_oe   <= 1'b1;
                                ack_held <= 1'b1;
                            end else begin
                                state  <= after;
                                bitcnt <= '0;
                                if (after == ST_TX) begin
                                    txreg  <= rd_byte;
                                    sda_oe <= ~rd_byte[7];
                                end else begin
                                    sda_oe <= 1'b0;
                                end
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_rise) begin
                            bitcnt <= bitcnt + 1'b1;
                        end else if (scl_fall) begin
                            if (bitcnt == 4'd8) begin
                                sda_oe <= 1'b0;
                                more   <= 1'b0;
                                state  <= ST_MACK;
                            end else begin
                                txreg  <= {txreg[6:0], 1'b0};
                                sda_oe <= ~txreg[6];
                            end
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) begin
                            if (!sda && is_wide(ptr) && idx == 2'd0) begin
                                more <= 1'b1;
                                idx  <= 2'd1;
                            end else begin
                                rd_done <= 1'b1;
                                state   <= ST_IDLE;
                            end
                        end else if (scl_fall && more) begin
                            more   <= 1'b0;
                            state  <= ST_TX;
                            bitcnt <= '0;
                            txreg  <= rd_byte;
                            sda_oe <= ~rd_byte[7];
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/tw_reg_slave.sv
module tw_reg_slave
    import tw_pkg::*;
#(
    parameter int TIMEOUT_CYC = 1000000,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        scl_in,
    input  logic        sda_in,
    input  logic [2:0]  dev_pins,
    input  logic [15:0] temp_in,
    output logic        sda_oe,
    output logic [7:0]  cfg_out,
    output logic [15:0] thyst_out,
    output logic [15:0] tos_out,
    output logic        rd_strobe
);
    logic [1:0] line_now, line_prev;
    logic       ptr_we, snap, rd_idx, soft_rst;
    reg_sel_e   ptr_val, ptr;
    wr_req_t    wr;
    logic [7:0] rd_byte;

    tw_line_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw    ({scl_in, sda_in}),
        .now_q  (line_now),
        .prev_q (line_prev)
    );

    tw_bus_fsm #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .scl      (line_now[1]),
        .scl_prev (line_prev[1]),
        .sda      (line_now[0]),
        .sda_prev (line_prev[0]),
        .dev_pins (dev_pins),
        .ptr      (ptr),
        .rd_byte  (rd_byte),
        .sda_oe   (sda_oe),
        .ptr_we   (ptr_we),
        .ptr_val  (ptr_val),
        .wr       (wr),
        .snap     (snap),
        .rd_idx   (rd_idx),
        .soft_rst (soft_rst),
        .rd_done  (rd_strobe)
    );

    tw_reg_file u_regs (
        .clk       (clk),
        .rst       (rst),
        .soft_rst  (soft_rst),
        .ptr_we    (ptr_we),
        .ptr_val   (ptr_val),
        .wr        (wr),
        .snap      (snap),
        .temp_in   (temp_in),
        .rd_idx    (rd_idx),
        .ptr       (ptr),
        .rd_byte   (rd_byte),
        .cfg_out   (cfg_out),
        .thyst_out (thyst_out),
        .tos_out   (tos_out)
    );
endmodule

// File: rtl/tw_reg_slave_chk.sv
module tw_reg_slave_chk #(
    parameter int TIMEOUT_CYC = 1000000
) (
    input logic        clk,
    input logic        rst,
    input logic        scl_in,
    input logic        sda_oe,
    input logic [7:0]  cfg_out,
    input logic [15:0] thyst_out,
    input logic [15:0] tos_out,
    input logic        rd_strobe
);
    int unsigned hold_cnt;

    always_ff @(posedge clk) begin
        if (rst)         hold_cnt <= 0;
        else if (sda_oe) hold_cnt <= hold_cnt + 1;
        else             hold_cnt <= 0;
    end

    assert_oe_bounded_R8: assert property (@(posedge clk) disable iff (rst)
        hold_cnt <= TIMEOUT_CYC);

    assert_strobe_single_R10: assert property (@(posedge clk) disable iff (rst)
        rd_strobe |=> !rd_strobe);

    assert_strobe_released_R10: assert property (@(posedge clk) disable iff (rst)
        rd_strobe |-> !sda_oe);

    assert_drive_scl_low_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_in);

    assert_cfg_update_scl_high_R5: assert property (@(posedge clk) disable iff (rst)
        !$stable(cfg_out) |-> scl_in);

    assert_trip_update_scl_high_R5: assert property (@(posedge clk) disable iff (rst)
        (!$stable(tos_out) || !$stable(thyst_out)) |-> scl_in);
endmodule

bind tw_reg_slave tw_reg_slave_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .scl_in    (scl_in),
    .sda_oe    (sda_oe),
    .cfg_out   (cfg_out),
    .thyst_out (thyst_out),
    .tos_out   (tos_out),
    .rd_strobe (rd_strobe)
);

// File: tb/test_tw_reg_slave.sv
module test_tw_reg_slave;
    localparam int TMO = 400;
    localparam int H   = 20;
    localparam logic [7:0] AW = 8'h9A;
    localparam logic [7:0] AR = 8'h9B;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl = 1'b1;
    logic        sda_m = 1'b1;
    logic [2:0]  pins = 3'b101;
    logic [15:0] temp = 16'h0000;
    logic        sda_oe, rd_strobe;
    logic [7:0]  cfg_out;
    logic [15:0] thyst_out, tos_out;
    wire         bus = sda_m & ~sda_oe;

    int errors = 0;
    int checks = 0;
    int strobes = 0;
    int exp_strobes = 0;
    bit cmp_on = 1'b0;
    logic [7:0]  exp_cfg = 8'h00;
    logic [15:0] exp_tos = 16'h5000;
    logic [15:0] exp_thyst = 16'h4B00;

    always #4 clk = ~clk;

    tw_reg_slave #(.TIMEOUT_CYC(TMO)) i_tw_reg_slave (
        .clk(clk), .rst(rst), .scl_in(scl), .sda_in(bus), .dev_pins(pins),
        .temp_in(temp), .sda_oe(sda_oe), .cfg_out(cfg_out),
        .thyst_out(thyst_out), .tos_out(tos_out), .rd_strobe(rd_strobe)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(posedge clk) if (!rst && rd_strobe) strobes++;

    // reference register model compared on every idle clock
    always @(negedge clk) begin
        if (cmp_on) begin
            chk(cfg_out == exp_cfg, "R3 model cfg", {24'h0, cfg_out}, {24'h0, exp_cfg});
            chk(tos_out == exp_tos, "R4 model tos", {16'h0, tos_out}, {16'h0, exp_tos});
            chk(thyst_out == exp_thyst, "R4 model thyst", {16'h0, thyst_out}, {16'h0, exp_thyst});
            chk(!sda_oe, "R5 idle release", {31'h0, sda_oe}, 0);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bstart();
        cmp_on = 1'b0;
        sda_m = 1'b1; tick(H);
        scl = 1'b1;   tick(H);
        sda_m = 1'b0; tick(H);
        scl = 1'b0;   tick(H);
    endtask

    task automatic bstop();
        sda_m = 1'b0; tick(H);
        scl = 1'b1;   tick(H);
        sda_m = 1'b1; tick(H);
        tick(4);
        cmp_on = 1'b1;
    endtask

    task automatic send_bits(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(H);
            scl = 1'b1;   tick(H);
            scl = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        send_bits(b);
        sda_m = 1'b1; tick(H);
        scl = 1'b1;   tick(H / 2);
        acked = !bus; tick(H / 2);
        scl = 1'b0;
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(H);
            scl = 1'b1; tick(H / 2);
            b[i] = bus; tick(H / 2);
            scl = 1'b0;
        end
        sda_m = mack ? 1'b0 : 1'b1; tick(H);
        scl = 1'b1; tick(H);
        scl = 1'b0;
        sda_m = 1'b1;
    endtask

    task automatic expect_ack(input logic [7:0] b, input bit exp, input string req);
        bit a;
        send_byte(b, a);
        chk(a == exp, req, {31'h0, a}, {31'h0, exp});
    endtask

    task automatic point_and_read(input logic [1:0] p, input bit two, output logic [15:0] w);
        logic [7:0] ms, ls;
        bstart(); expect_ack(AW, 1, "R1 addr");
        expect_ack({6'h0, p}, 1, "R5 ptr ack");
        bstart(); expect_ack(AR, 1, "R9 read addr");
        recv_byte(two, ms);
        ls = 8'h00;
        if (two) recv_byte(0, ls);
        bstop();
        w = {ms, ls};
    endtask

    task automatic sticky_read(input bit two, output logic [15:0] w);
        logic [7:0] ms, ls;
        bstart(); expect_ack(AR, 1, "R2 read addr");
        recv_byte(two, ms);
        ls = 8'h00;
        if (two) recv_byte(0, ls);
        bstop();
        w = {ms, ls};
    endtask

    initial begin
        logic [15:0] w;
        logic [7:0] b;
        tick(5);
        rst = 1'b0;
        tick(3);
        // R12 reset values
        chk(cfg_out == 8'h00, "R12 cfg reset", {24'h0, cfg_out}, 0);
        chk(tos_out == 16'h5000, "R12 tos reset", {16'h0, tos_out}, 32'h5000);
        chk(thyst_out == 16'h4B00, "R12 thyst reset", {16'h0, thyst_out}, 32'h4B00);
        chk(!sda_oe && !rd_strobe, "R12 outputs low", {30'h0, sda_oe, rd_strobe}, 0);
        cmp_on = 1'b1;

        // R2 default pointer, R11 low nibble cleared
        temp = 16'h7D0F;
        sticky_read(1, w);
        chk(w == 16'h7D00, "R2 R11 default temp read", {16'h0, w}, 32'h7D00);
        exp_strobes++;
        chk(strobes == exp_strobes, "R10 strobe count", strobes, exp_strobes);

        // R3 config write, bit 7 reads zero; R9 repeated start read
        bstart(); expect_ack(AW, 1, "R1 addr"); expect_ack(8'h01, 1, "R5 ptr");
        expect_ack(8'hFF, 1, "R5 cfg data"); exp_cfg = 8'h7F; bstop();
        point_and_read(2'b01, 0, w);
        chk(w[15:8] == 8'h7F, "R3 R9 cfg readback", {24'h0, w[15:8]}, 32'h7F);
        exp_strobes++;
        sticky_read(0, w);
        chk(w[15:8] == 8'h7F, "R2 sticky pointer", {24'h0, w[15:8]}, 32'h7F);
        exp_strobes++;
        chk(strobes == exp_strobes, "R10 strobe count", strobes, exp_strobes);

        // R4 trip writes and reads
        bstart(); expect_ack(AW, 1, "R1 addr"); expect_ack(8'h03, 1, "R5 ptr");
        expect_ack(8'h12, 1, "R4 tos ms"); expect_ack(8'h3F, 1, "R4 tos ls");
        exp_tos = 16'h1230; bstop();
        bstart(); expect_ack(AW, 1, "R1 addr"); expect_ack(8'h02, 1, "R5 ptr");
        expect_ack(8'hF5, 1, "R4 thyst ms"); expect_ack(8'hE7, 1, "R4 thyst ls");
        exp_thyst = 16'hF5E0; bstop();
        point_and_read(2'b11, 1, w);
        chk(w == 16'h1230, "R4 tos readback", {16'h0, w}, 32'h1230);
        exp_strobes++;

        // R6 MS byte only
        point_and_read(2'b10, 0, w);
        chk(w[15:8] == 8'hF5, "R6 ms only read", {24'h0, w[15:8]}, 32'hF5);
        exp_strobes++;
        chk(strobes == exp_strobes, "R6 R10 strobe after ms nack", strobes, exp_strobes);

        // R1 foreign addresses
        bstart(); expect_ack(8'h90, 0, "R1 wrong pins"); bstop();
        bstart(); expect_ack(8'hDA, 0, "R1 wrong prefix"); bstop();

        // R5 rejected writes
        bstart(); expect_ack(AW, 1, "R1 addr"); expect_ack(8'h00, 1, "R5 ptr temp");
        expect_ack(8'h33, 0, "R5 temp write nack"); bstop();
        bstart(); expect_ack(AW, 1, "R1 addr"); expect_ack(8'h03, 1, "R5 ptr");
        expect_ack(8'h0A, 1, "R5 tos ms"); expect_ack(8'h2F, 1, "R5 tos ls");
        exp_tos = 16'h0A20;
        expect_ack(8'h77, 0, "R5 third byte nack"); bstop();
        chk(tos_out == 16'h0A20, "R5 tos after extra byte", {16'h0, tos_out}, 32'h0A20);

        // R7 soft reset
        bstart(); expect_ack(AW, 1, "R1 addr");
        expect_ack(8'h54, 0, "R7 command nack");
        exp_cfg = 8'h00; exp_tos = 16'h5000; exp_thyst = 16'h4B00;
        bstop();
        temp = 16'hC900;
        sticky_read(1, w);
        chk(w == 16'hC900, "R7 pointer back to temp", {16'h0, w}, 32'hC900);
        exp_strobes++;

        // R11 snapshot across bytes
        temp = 16'h1910;
        bstart(); expect_ack(AR, 1, "R11 addr");
        recv_byte(1, b);
        chk(b == 8'h19, "R11 ms byte", {24'h0, b}, 32'h19);
        temp = 16'hE6F0;
        recv_byte(0, b);
        chk(b == 8'h10, "R11 ls from snapshot", {24'h0, b}, 32'h10);
        bstop();
        exp_strobes++;
        sticky_read(1, w);
        chk(w == 16'hE6F0, "R11 new value next read", {16'h0, w}, 32'hE6F0);
        exp_strobes++;
        chk(strobes == exp_strobes, "R10 strobe count", strobes, exp_strobes);

        // R8 foreign low hold does not time out
        bstart(); expect_ack(AW, 1, "R1 addr"); expect_ack(8'h01, 1, "R5 ptr");
        sda_m = 1'b0; tick(TMO + 200);
        chk(!sda_oe, "R8 foreign low no drive", {31'h0, sda_oe}, 0);
        expect_ack(8'h05, 1, "R8 ack after foreign hold");
        exp_cfg = 8'h05; bstop();

        // R8 own low hold times out
        bstart(); send_bits(AW);
        sda_m = 1'b1; tick(TMO / 2);
        chk(sda_oe, "R8 ack held before limit", {31'h0, sda_oe}, 1);
        tick(TMO / 2 + 100);
        chk(!sda_oe, "R8 released after limit", {31'h0, sda_oe}, 0);
        bstop();
        point_and_read(2'b01, 0, w);
        chk(w[15:8] == 8'h05, "R8 recovers after timeout", {24'h0, w[15:8]}, 32'h05);
        exp_strobes++;
        chk(strobes == exp_strobes, "R10 strobe count", strobes, exp_strobes);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule